// File: doc/BRIEF.md
# Inline Watermark Checker

This block sits beside a stream of 32-bit plaintext image words and tests the stream for embedded 16-byte watermark frames. A frame is four consecutive words and may begin on any word. Its opening word carries a 20-bit IV, two sense bits and a 10-bit position tag. The tag must equal the low ten bits of the word's address for the frame to be tested. The three words that follow are checksums of the opening word, keyed with a secret that the host loads one bit at a time.

Each check word is compared against successive states of a 32-bit Galois LFSR. The LFSR is seeded with the opening word XOR the working key. When a tested frame fails, a sticky kill flag rises; the host reads it at a time of its own choosing. A seek strobe realigns the working key to a new stream position and drops any frame in flight. Only power-on reset clears the kill flag.

Top module: `wm_inline_checker`

## Requirements
- R1: After power-on reset (rst_ni low), kill_o is 0, and both the staging key and the working key are all zeros. A frame built with a zero key then verifies, with no seek needed.
- R2: Word layout is bits [9:0] position tag, bits [11:10] sense, bits [31:12] IV. While no frame is open, a valid word opens a frame when bits [9:0] equal wd_addr_i. The sense and IV bits never affect that decision.
- R3: Check word k (k = 1..3) must equal step^k(first XOR working key). Here step(s) = (s >> 1) XOR (s[0] ? 32'hD000_0001 : 0), and "first" is the opening word.
- R4: A check word that differs from its expected value sets kill_o. The flag is visible after the clock edge that samples that word, and the frame is dropped at once.
- R5: A frame whose three check words all match leaves kill_o unchanged. The word after the third check word is again tested as a possible opening word.
- R6: While no frame is open, a valid word whose bits [9:0] differ from wd_addr_i is ignored.
- R7: While a frame is open, every valid word is taken as its next check word, even when its bits [9:0] equal its address.
- R8: With key_shift_i high, key_bit_i enters the LSB of the staging key and the other bits move one place up. The staging key has no effect on checking until a seek.
- R9: A seek loads the working key with the staging key rotated left by seek_rot_i. It drops any open frame with no verdict. A word presented in the same cycle as a seek is ignored.
- R10: Each time a frame opens, the working key is used for the seed and then rotated left by one bit.
- R11: kill_o stays 1 once set. A seek does not clear it; only rst_ni does.
- R12: Cycles with wd_valid_i low change neither the frame in progress nor kill_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asserted asynchronously, released synchronously inside |
| wd_valid_i | input | 1 | Stream word present this cycle |
| wd_addr_i | input | 10 | Low ten bits of the stream word's address |
| wd_data_i | input | 32 | Stream word |
| key_shift_i | input | 1 | Shift one key bit into the staging key |
| key_bit_i | input | 1 | Key bit shifted in |
| seek_i | input | 1 | Seek strobe: reload the working key and drop any open frame |
| seek_rot_i | input | 5 | Left rotation applied to the staging key on seek |
| kill_o | output | 1 | Sticky watermark failure flag |

## Verification
The bound assertions watch properties that hold on every cycle: kill stays set once raised, and it rises only after a check word is taken. A seek always leaves the tracker idle, and a word without a tag match never opens a frame. Idle stream cycles change nothing, and the working key moves only on a seek or a frame opening. Whether the checksum values themselves are right can be shown only by the bench. It builds frames from its own LFSR and key-rotation model, corrupts chosen check words, and interleaves seeks, key shifts and look-alike opening words. It then observes kill_o.

// File: rtl/wm_pkg.sv
package wm_pkg;

  typedef enum logic {
    TRK_IDLE  = 1'b0,
    TRK_CHECK = 1'b1
  } trk_state_e;

  localparam int unsigned WM_DATA_W   = 32;
  localparam int unsigned WM_TAG_W    = 10;
  localparam int unsigned WM_FRAME_WD = 4;
  localparam logic [31:0] WM_POLY     = 32'hD000_0001;

endpackage

// File: rtl/wm_rst_sync.sv
module wm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/wm_key_store.sv
module wm_key_store #(
  parameter int unsigned KEY_W = 32,
  localparam int unsigned ROT_W = $clog2(KEY_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             seek_i,
  input  logic [ROT_W-1:0] seek_rot_i,
  input  logic             advance_i,
  output logic [KEY_W-1:0] work_key_o
);

  logic [KEY_W-1:0] stage_q, stage_d;
  logic [KEY_W-1:0] work_q, work_d;
  logic             stage_en, work_en;
  logic [2*KEY_W-1:0] stage_dbl;
  logic [KEY_W-1:0] stage_rot;
  logic [KEY_W-1:0] work_rot1;

  // rotate-left by a variable amount through a doubled copy
  always_comb begin
    stage_dbl = {stage_q, stage_q};
    stage_rot = stage_dbl[(KEY_W - int'(seek_rot_i)) +: KEY_W];
  end

  assign work_rot1 = {work_q[KEY_W-2:0], work_q[KEY_W-1]};

  always_comb begin
    stage_en = shift_i;
    stage_d  = {stage_q[KEY_W-2:0], bit_i};
  end

  always_comb begin
    work_en = seek_i | advance_i;
    work_d  = work_q;
    if (seek_i) begin
      work_d = stage_rot;
    end else if (advance_i) begin
      work_d = work_rot1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  assign work_key_o = work_q;

endmodule

// File: rtl/wm_frame_tracker.sv
module wm_frame_tracker
  import wm_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = 10,
  parameter int unsigned FRAME_WD  = 4,
  parameter logic [DATA_W-1:0] POLY = 32'hD000_0001,
  localparam int unsigned CHK_WD   = FRAME_WD - 1,
  localparam int unsigned CNT_W    = $clog2(CHK_WD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              seek_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              start_o,
  output logic              fail_o,
  output logic              busy_o
);

  trk_state_e        st_q, st_d;
  logic [DATA_W-1:0] lfsr_q, lfsr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              reg_en;
  logic              tag_hit;
  logic              take_chk;
  logic              mism;
  logic              last_chk;

  function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s);
    lfsr_step = {1'b0, s[DATA_W-1:1]} ^ (s[0] ? POLY : '0);
  endfunction

  assign tag_hit  = (data_i[TAG_W-1:0] == addr_i);
  assign start_o  = (st_q == TRK_IDLE) && valid_i && !seek_i && tag_hit;
  assign take_chk = (st_q == TRK_CHECK) && valid_i && !seek_i;
  assign mism     = take_chk && (data_i != lfsr_q);
  assign last_chk = (cnt_q == CNT_W'(CHK_WD));

  always_comb begin
    st_d   = st_q;
    lfsr_d = lfsr_q;
    cnt_d  = cnt_q;
    reg_en = seek_i | start_o | take_chk;
    if (seek_i) begin
      st_d  = TRK_IDLE;
      cnt_d = '0;
    end else if (start_o) begin
      st_d   = TRK_CHECK;
      lfsr_d = lfsr_step(data_i ^ key_i);
      cnt_d  = CNT_W'(1);
    end else if (take_chk) begin
      if (mism || last_chk) begin
        st_d  = TRK_IDLE;
        cnt_d = '0;
      end else begin
        lfsr_d = lfsr_step(lfsr_q);
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TRK_IDLE;
      lfsr_q <= '0;
      cnt_q  <= '0;
    end else if (reg_en) begin
      st_q   <= st_d;
      lfsr_q <= lfsr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign fail_o = mism;
  assign busy_o = (st_q == TRK_CHECK);

endmodule

// File: rtl/wm_kill_latch.sv
module wm_kill_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  output logic kill_o
);

  logic kill_q;
  logic kill_en;

  assign kill_en = fail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_q <= 1'b0;
    end else if (kill_en) begin
      kill_q <= 1'b1;
    end
  end

  assign kill_o = kill_q;

endmodule

// File: rtl/wm_inline_checker.sv
module wm_inline_checker
  import wm_pkg::*;
#(
  parameter int unsigned DATA_W   = WM_DATA_W,
  parameter int unsigned TAG_W    = WM_TAG_W,
  parameter int unsigned FRAME_WD = WM_FRAME_WD,
  parameter logic [DATA_W-1:0] POLY = WM_POLY,
  localparam int unsigned ROT_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wd_valid_i,
  input  logic [TAG_W-1:0]  wd_addr_i,
  input  logic [DATA_W-1:0] wd_data_i,
  input  logic              key_shift_i,
  input  logic              key_bit_i,
  input  logic              seek_i,
  input  logic [ROT_W-1:0]  seek_rot_i,
  output logic              kill_o
);

  logic              rst_sync_n;
  logic [DATA_W-1:0] work_key;
  logic              trk_start;
  logic              trk_fail;
  logic              trk_busy;

  wm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  wm_key_store #(.KEY_W(DATA_W)) u_key_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .shift_i    (key_shift_i),
    .bit_i      (key_bit_i),
    .seek_i     (seek_i),
    .seek_rot_i (seek_rot_i),
    .advance_i  (trk_start),
    .work_key_o (work_key)
  );

  wm_frame_tracker #(
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W),
    .FRAME_WD (FRAME_WD),
    .POLY     (POLY)
  ) u_tracker (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .valid_i (wd_valid_i),
    .addr_i  (wd_addr_i),
    .data_i  (wd_data_i),
    .seek_i  (seek_i),
    .key_i   (work_key),
    .start_o (trk_start),
    .fail_o  (trk_fail),
    .busy_o  (trk_busy)
  );

  wm_kill_latch u_kill (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .fail_i (trk_fail),
    .kill_o (kill_o)
  );

endmodule

// File: rtl/wm_checker_sva.sv
module wm_checker_sva #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TAG_W    = 10,
  parameter int unsigned FRAME_WD = 4
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              valid,
  input logic [TAG_W-1:0]  addr,
  input logic [DATA_W-1:0] data,
  input logic              seek,
  input logic              start,
  input logic              busy,
  input logic              kill,
  input logic [DATA_W-1:0] work_key
);

  localparam int unsigned CHK_WD = FRAME_WD - 1;
  localparam int unsigned CNT_W  = $clog2(CHK_WD + 2);

  logic             tag_hit;
  logic [CNT_W-1:0] seen_q;

  assign tag_hit = (data[TAG_W-1:0] == addr);

  // count check words taken while a frame is open
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (!busy) begin
      seen_q <= '0;
    end else if (valid && !seek && seen_q <= CNT_W'(CHK_WD)) begin
      seen_q <= seen_q + CNT_W'(1);
    end
  end

  AST_KILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    kill |=> kill); // R11

  AST_KILL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(kill) |-> $past(busy && valid && !seek)); // R4

  AST_SEEK_ABORT: assert property (@(posedge clk_i) disable iff (!rst_n)
    seek |=> !busy); // R9

  AST_NO_TAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy && valid && !seek && !tag_hit) |=> !busy); // R6

  AST_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!valid && !seek) |=> ($stable(busy) && $stable(kill))); // R12

  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy |-> (seen_q < CNT_W'(CHK_WD))); // R5

  AST_KEY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!seek && !start) |=> $stable(work_key)); // R8

endmodule

bind wm_inline_checker wm_checker_sva #(
  .DATA_W   (DATA_W),
  .TAG_W    (TAG_W),
  .FRAME_WD (FRAME_WD)
) u_sva (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .valid    (wd_valid_i),
  .addr     (wd_addr_i),
  .data     (wd_data_i),
  .seek     (seek_i),
  .start    (trk_start),
  .busy     (trk_busy),
  .kill     (kill_o),
  .work_key (work_key)
);

// File: tb/test_wm_inline_checker.sv
`timescale 1ns/1ps
module test_wm_inline_checker;

  localparam logic [31:0] POLY = 32'hD000_0001;
  localparam logic [31:0] KEY0 = 32'h5EC0_3A71;
  localparam logic [31:0] KEY1 = 32'h9B1D_44E6;
  localparam int NV = 6;
  // {tag[9:0], iv[19:0], sense[1:0], corrupt idx[1:0], rot[4:0], exp kill}
  localparam logic [39:0] VEC [NV] = '{
    {10'h010, 20'hABCDE, 2'd0, 2'd0, 5'd0,  1'b0},
    {10'h3FF, 20'h00001, 2'd3, 2'd1, 5'd0,  1'b1},
    {10'h000, 20'hFFFFF, 2'd2, 2'd2, 5'd7,  1'b1},
    {10'h155, 20'h12345, 2'd1, 2'd3, 5'd31, 1'b1},
    {10'h2AA, 20'h0F0F0, 2'd3, 2'd0, 5'd13, 1'b0},
    {10'h001, 20'h00000, 2'd0, 2'd0, 5'd1,  1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wd_valid_i;
  logic [9:0]  wd_addr_i;
  logic [31:0] wd_data_i;
  logic        key_shift_i;
  logic        key_bit_i;
  logic        seek_i;
  logic [4:0]  seek_rot_i;
  logic        kill_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] m_stage, m_work;

  always #2 clk_i = ~clk_i;

  wm_inline_checker i_wm_inline_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .wd_valid_i(wd_valid_i),
    .wd_addr_i(wd_addr_i), .wd_data_i(wd_data_i), .key_shift_i(key_shift_i),
    .key_bit_i(key_bit_i), .seek_i(seek_i), .seek_rot_i(seek_rot_i),
    .kill_o(kill_o)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    step = {1'b0, s[31:1]} ^ (s[0] ? POLY : 32'h0);
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] x, input int r);
    logic [31:0] y = x;
    for (int i = 0; i < r; i++) y = {y[30:0], y[31]};
    rotl = y;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    wd_valid_i = 1'b0; seek_i = 1'b0; key_shift_i = 1'b0;
    wd_data_i = 32'hDEAD_BEE5;
  endtask

  task automatic por();
    @(negedge clk_i);
    rst_ni = 1'b0; wd_valid_i = 1'b0; seek_i = 1'b0; key_shift_i = 1'b0;
    key_bit_i = 1'b0; seek_rot_i = '0; wd_addr_i = '0; wd_data_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    m_stage = '0; m_work = '0;
  endtask

  task automatic word(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wd_valid_i = 1'b1; wd_addr_i = a; wd_data_i = d; seek_i = 1'b0; key_shift_i = 1'b0;
  endtask

  task automatic load_key(input logic [31:0] k);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk_i);
      wd_valid_i = 1'b0; seek_i = 1'b0; key_shift_i = 1'b1; key_bit_i = k[i];
      m_stage = {m_stage[30:0], k[i]};
    end
    idle();
  endtask

  task automatic seek(input logic [4:0] r);
    @(negedge clk_i);
    wd_valid_i = 1'b0; key_shift_i = 1'b0; seek_i = 1'b1; seek_rot_i = r;
    m_work = rotl(m_stage, int'(r));
    idle();
  endtask

  function automatic logic [31:0] opener(input logic [9:0] a, input logic [19:0] iv, input logic [1:0] sn);
    opener = {iv, sn, a};
  endfunction

  // sends a frame; corrupt = 0 for none, 1..3 flips a bit in that check word
  task automatic frame(input logic [9:0] a, input logic [19:0] iv, input logic [1:0] sn,
                       input int corrupt);
    logic [31:0] f, s;
    f = opener(a, iv, sn);
    s = step(f ^ m_work);
    m_work = rotl(m_work, 1);
    word(a, f);
    for (int k = 1; k <= 3; k++) begin
      word(a + 10'(k), (k == corrupt) ? (s ^ (32'h1 << k)) : s);
      s = step(s);
      if (k == corrupt) break;
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    // vector table: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      por();
      load_key(KEY0);
      seek(VEC[v][5:1]);
      frame(VEC[v][39:30], VEC[v][29:10], VEC[v][9:8], int'(VEC[v][7:6]));
      check($sformatf("R3/R4/R5 vector %0d", v), {31'd0, kill_o}, {31'd0, VEC[v][0]});
    end

    // R1: reset state and zero key
    por();
    check("R1 kill after reset", {31'd0, kill_o}, 32'd0);
    frame(10'h0AB, 20'h55555, 2'd1, 0);
    check("R1 zero key frame", {31'd0, kill_o}, 32'd0);

    // R6: untagged words ignored, then a real frame still verifies
    for (int i = 0; i < 20; i++) word(10'(i), {22'h3A5A5A, 10'(i) ^ 10'h155});
    idle();
    check("R6 untagged ignored", {31'd0, kill_o}, 32'd0);
    frame(10'h020, 20'hC0FFE, 2'd2, 0);
    check("R6 frame after noise", {31'd0, kill_o}, 32'd0);

    // R12: invalid cycles inside a frame
    begin
      logic [31:0] f, s;
      f = opener(10'h040, 20'h2468A, 2'd0);
      s = step(f ^ m_work); m_work = rotl(m_work, 1);
      word(10'h040, f);
      for (int k = 1; k <= 3; k++) begin
        idle(); idle();
        word(10'h040 + 10'(k), s); s = step(s);
      end
      idle();
      check("R12 gaps inside frame", {31'd0, kill_o}, 32'd0);
    end

    // R8: staged key has no effect before seek
    load_key(KEY1);
    frame(10'h111, 20'h0BEEF, 2'd3, 0);
    check("R8 staged key inert", {31'd0, kill_o}, 32'd0);
    seek(5'd3);
    frame(10'h112, 20'hFACE1, 2'd1, 0);
    check("R8 staged key after seek", {31'd0, kill_o}, 32'd0);

    // R10: back-to-back frames with rotating key
    frame(10'h200, 20'h11111, 2'd0, 0);
    frame(10'h204, 20'h22222, 2'd1, 0);
    frame(10'h208, 20'h33333, 2'd2, 0);
    check("R10 rotated key frames", {31'd0, kill_o}, 32'd0);

    // R9: seek drops open frame; word during seek ignored
    begin
      logic [31:0] f;
      f = opener(10'h300, 20'h99999, 2'd0);
      word(10'h300, f);
      m_work = rotl(m_work, 1);
      word(10'h301, step(f ^ rotl(m_work, 31)));
      @(negedge clk_i);
      wd_valid_i = 1'b1; wd_addr_i = 10'h302; wd_data_i = opener(10'h302, 20'h1, 2'd0);
      seek_i = 1'b1; seek_rot_i = 5'd9; m_work = rotl(m_stage, 9);
      word(10'h303, 32'h0000_0000);
      idle();
      check("R9 seek abort and ignore", {31'd0, kill_o}, 32'd0);
    end

    // R7: tagged word inside a frame is a check word, so it fails
    begin
      logic [31:0] f;
      f = opener(10'h050, 20'h7E7E7, 2'd2);
      m_work = rotl(m_work, 1);
      word(10'h050, f);
      word(10'h051, opener(10'h051, 20'h00042, 2'd0));
      idle();
      check("R7/R4 tagged check word", {31'd0, kill_o}, 32'd1);
    end

    // R11: sticky across seek and good frames, cleared by reset
    seek(5'd0);
    check("R11 kill after seek", {31'd0, kill_o}, 32'd1);
    frame(10'h060, 20'h0A0A0, 2'd0, 0);
    check("R11 kill after good frame", {31'd0, kill_o}, 32'd1);
    por();
    check("R11/R1 kill cleared by reset", {31'd0, kill_o}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule